// File: doc/BRIEF.md
# Processor Reset Vector Fetch Sequencer

This block takes a 32-bit processor core from reset to its first instruction. Reset clears the architectural register bank and loads the status register with its reset image, 0x2700. In that image the supervisor bit and interrupt mask level 7 are set and every condition flag is clear. The sequencer then waits in an initial state for a step request.

The first step request starts the vector fetch. The initial supervisor stack pointer comes from the big-endian long at byte address 0 and the initial program counter from the long at byte address 4. Each long is read as two 16-bit words over a request/acknowledge read port, high word first.

Once the program counter is loaded, the block is running. A later step request raises a go signal to the execution stage, which holds it until that stage reports completion. A halt request parks the block in a halted state from any state. While halted it refuses steps with a one-cycle error pulse, and only reset leaves that state.

Top module: `reset_vector_seq`

## Requirements
- R1: After reset `running` is 1, `busy`, `rd_req`, `exec_go` and `step_err` are 0, and `sr_out` reads 0x2700.
- R2: After reset every bank entry reads zero through `arch_sel`. The bank order is: data registers 0-7 at selects 0-7, address registers 0-6 at selects 8-14, supervisor stack pointer at 15, user stack pointer at 16, vector base at 17, program counter at 18. A select of 19 or above reads zero.
- R3: A step request in the initial state raises `rd_req` and `busy` on the next cycle. The fetch then reads word addresses 0, 2, 4 and 6 in that order, and `rd_addr` and `rd_req` stay unchanged until `rd_ack` is seen, however long that takes.
- R4: The supervisor stack pointer (select 15) becomes {word at 0, word at 2} and the program counter (select 18) becomes {word at 4, word at 6}.
- R5: `busy` stays high from the first read until the cycle after the last acknowledge; then `busy` and `rd_req` are 0 and `running` is 1.
- R6: In the running state a step request raises `exec_go` on the next cycle. `exec_go` stays high, with further step requests ignored, until `step_done`; it falls on the cycle after `step_done`.
- R7: `halt_req` in any state makes `running`, `rd_req`, `busy` and `exec_go` 0 on the next cycle, and aborts a fetch in progress.
- R8: A step request while halted gives a one-cycle `step_err` pulse on the next cycle and leaves the block halted; only reset restarts it.
- R9: A step request while the fetch is in progress is ignored: the address sequence continues unchanged.
- R10: The status register keeps 0x2700 through the fetch, execution handshakes and halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Step request from the core's scheduler |
| step_done | input | 1 | Execution stage finished its instruction |
| halt_req | input | 1 | Force the halted state |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | AW (24) | Byte address of the 16-bit word being read |
| rd_ack | input | 1 | Read data valid, completes the request |
| rd_data | input | 16 | Read data word |
| busy | output | 1 | Vector fetch in progress |
| running | output | 1 | High in every state except halted |
| exec_go | output | 1 | Execute one instruction, held until step_done |
| step_err | output | 1 | Step refused because the block is halted |
| sr_out | output | 16 | Status register |
| arch_sel | input | SEL_W (5) | Register bank read select |
| arch_rdata | output | 32 | Selected bank register |

## Verification
A wrong word index or a wrongly assembled long shows up in the two bank entries read back the cycle after the final acknowledge. A word swap or an off-by-two address is therefore visible within one cycle of the fetch ending. A state register that leaves the fetch too early or too late shows at `busy` and `rd_req`, and a stuck execute handshake shows at `exec_go`, each on the cycle after the triggering input. Halt and refusal errors show directly at `running` and `step_err` one cycle later. Slow acknowledges stress the hold of address and request while the acknowledge is pending.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RUN   = 3'd2,
    ST_EXEC  = 3'd3,
    ST_HALT  = 3'd4
  } seq_state_e;

  localparam logic [15:0] SR_RESET = 16'h2700;

  // two big-endian words into one long, first word is the upper half
  function automatic logic [31:0] join_words(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  // byte address of the n-th vector word
  function automatic logic [31:0] vec_word_addr(input logic [1:0] n);
    return {29'd0, n, 1'b0};
  endfunction

endpackage

// File: rtl/rvs_fetch_ctrl.sv
module rvs_fetch_ctrl
  import rvs_pkg::*;
#(
  parameter int AW      = 24,
  parameter int SEL_W   = 5,
  parameter int IDX_SSP = 15,
  parameter int IDX_PC  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             step_done,
  input  logic             halt_req,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [15:0]      rd_data,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_idx,
  output logic [31:0]      wr_val,
  output logic             busy,
  output logic             running,
  output logic             exec_go,
  output logic             step_err
);

  seq_state_e state_q, state_d;
  logic [1:0]  widx_q;
  logic [15:0] hi_q;
  logic        err_q;
  logic        word_fire;
  logic        long_done;
  logic [31:0] addr_full;

  assign addr_full = vec_word_addr(widx_q);
  assign rd_req    = (state_q == ST_FETCH);
  assign rd_addr   = addr_full[AW-1:0];
  assign word_fire = rd_req && rd_ack && !halt_req;
  assign long_done = word_fire && widx_q[0];

  assign wr_en  = long_done;
  assign wr_idx = widx_q[1] ? SEL_W'(IDX_PC) : SEL_W'(IDX_SSP);
  assign wr_val = join_words(hi_q, rd_data);

  assign busy     = (state_q == ST_FETCH);
  assign running  = (state_q != ST_HALT);
  assign exec_go  = (state_q == ST_EXEC);
  assign step_err = err_q;

  always_comb begin
    state_d = state_q;
    if (halt_req) begin
      state_d = ST_HALT;
    end else begin
      case (state_q)
        ST_INIT:  if (step_req) state_d = ST_FETCH;
        ST_FETCH: if (long_done && widx_q == 2'd3) state_d = ST_RUN;
        ST_RUN:   if (step_req) state_d = ST_EXEC;
        ST_EXEC:  if (step_done) state_d = ST_RUN;
        default:  state_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      widx_q  <= 2'd0;
      hi_q    <= 16'd0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_HALT) && step_req;
      if (word_fire) begin
        widx_q <= widx_q + 2'd1;
        if (!widx_q[0]) hi_q <= rd_data;
      end
    end
  end

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !halt_req) |=> (rd_req && $stable(rd_addr)));

  a_r5_busy_ends_running: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (running || $past(halt_req)));

  a_r6_exec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && !step_done && !halt_req) |=> exec_go);

  a_r7_halt_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!running && !rd_req && !exec_go && !busy));

  a_r8_err_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> ($past(step_req) && !running));

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !running);

endmodule

// File: rtl/rvs_arch_bank.sv
module rvs_arch_bank #(
  parameter int NREG    = 19,
  parameter int SEL_W   = 5,
  parameter int IDX_SSP = 15,
  parameter int IDX_PC  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [31:0]      wr_val,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_val
);

  logic [31:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 regs[g] <= 32'd0;
      else if (wr_en && wr_idx == SEL_W'(g))      regs[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val = 32'd0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel == SEL_W'(i)) rd_val = regs[i];
    end
  end

  // only the two vector targets are loaded by the sequencer (R4)
  a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx == SEL_W'(IDX_SSP) || wr_idx == SEL_W'(IDX_PC)));

  initial begin
    a_r2_sel_fits: assert ((1 << SEL_W) > NREG);
  end

endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int AW       = 24,
  parameter int NUM_DATA = 8,
  parameter int NUM_ADDR = 7,
  parameter int SEL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             step_done,
  input  logic             halt_req,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [15:0]      rd_data,
  output logic             busy,
  output logic             running,
  output logic             exec_go,
  output logic             step_err,
  output logic [15:0]      sr_out,
  input  logic [SEL_W-1:0] arch_sel,
  output logic [31:0]      arch_rdata
);

  localparam int IDX_SSP = NUM_DATA + NUM_ADDR;
  localparam int IDX_PC  = IDX_SSP + 3;
  localparam int NREG    = IDX_PC + 1;

  logic             wr_en;
  logic [SEL_W-1:0] wr_idx;
  logic [31:0]      wr_val;
  logic [15:0]      sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= SR_RESET;
    else        sr_q <= sr_q;
  end
  assign sr_out = sr_q;

  rvs_fetch_ctrl #(
    .AW(AW), .SEL_W(SEL_W), .IDX_SSP(IDX_SSP), .IDX_PC(IDX_PC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .step_req(step_req), .step_done(step_done), .halt_req(halt_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .busy(busy), .running(running), .exec_go(exec_go), .step_err(step_err)
  );

  rvs_arch_bank #(
    .NREG(NREG), .SEL_W(SEL_W), .IDX_SSP(IDX_SSP), .IDX_PC(IDX_PC)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_sel(arch_sel), .rd_val(arch_rdata)
  );

  a_r10_sr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || exec_go || !running) |=> $stable(sr_out));

endmodule

// File: tb/reset_vector_seq_tb.sv
module reset_vector_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_req = 1'b0, step_done = 1'b0, halt_req = 1'b0;
  logic        rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data = 16'd0;
  logic        busy, running, exec_go, step_err;
  logic [15:0] sr_out;
  logic [4:0]  arch_sel = 5'd0;
  logic [31:0] arch_rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_vector_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_done(step_done),
    .halt_req(halt_req), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .busy(busy), .running(running), .exec_go(exec_go),
    .step_err(step_err), .sr_out(sr_out), .arch_sel(arch_sel), .arch_rdata(arch_rdata)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step_req = 0; step_done = 0; halt_req = 0; rd_ack = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_step();
    step_req = 1'b1; @(negedge clk); step_req = 1'b0;
  endtask

  task automatic rd_bank(input int sel, output logic [31:0] v);
    arch_sel = 5'(sel); #1; v = arch_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    chk("R1 running", 32'(running), 1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 exec_go", 32'(exec_go), 0);
    chk("R1 step_err", 32'(step_err), 0);
    chk("R1 sr", 32'(sr_out), 32'h2700);
    for (int s = 0; s < 21; s++) begin
      rd_bank(s, v);
      chk($sformatf("R2 bank sel %0d", s), v, 0);
    end
  endtask

  // serve the four vector words; extra step request during the first wait (R9)
  task automatic t_fetch(input logic [15:0] w0, w1, w2, w3, input int dly);
    logic [15:0] words [4];
    logic [31:0] v;
    words[0] = w0; words[1] = w1; words[2] = w2; words[3] = w3;
    pulse_step();
    chk("R3 busy up", 32'(busy), 1);
    chk("R3 rd_req up", 32'(rd_req), 1);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R3 addr word %0d", k), 32'(rd_addr), 32'(k * 2));
      for (int d = 0; d < dly; d++) begin
        if (k == 0 && d == 0) step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        chk($sformatf("R3 hold req w%0d", k), 32'(rd_req), 1);
        chk($sformatf("R9 R3 hold addr w%0d", k), 32'(rd_addr), 32'(k * 2));
        chk("R5 busy during fetch", 32'(busy), 1);
      end
      rd_ack = 1'b1; rd_data = words[k];
      @(negedge clk);
      rd_ack = 1'b0; rd_data = 16'hxxxx;
    end
    chk("R5 busy low", 32'(busy), 0);
    chk("R5 rd_req low", 32'(rd_req), 0);
    chk("R5 running", 32'(running), 1);
    rd_bank(15, v); chk("R4 ssp", v, {w0, w1});
    rd_bank(18, v); chk("R4 pc", v, {w2, w3});
    rd_bank(16, v); chk("R4 usp untouched", v, 0);
    chk("R10 sr after fetch", 32'(sr_out), 32'h2700);
  endtask

  task automatic t_exec();
    pulse_step();
    chk("R6 exec_go up", 32'(exec_go), 1);
    step_req = 1'b1; cyc(3); step_req = 1'b0;
    chk("R6 exec_go held", 32'(exec_go), 1);
    step_done = 1'b1; @(negedge clk); step_done = 1'b0;
    chk("R6 exec_go down", 32'(exec_go), 0);
    cyc(1);
    chk("R6 stays idle", 32'(exec_go), 0);
    pulse_step();
    chk("R6 second step", 32'(exec_go), 1);
    chk("R10 sr in exec", 32'(sr_out), 32'h2700);
  endtask

  task automatic t_halt();
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    chk("R7 running low", 32'(running), 0);
    chk("R7 exec_go low", 32'(exec_go), 0);
    chk("R8 no err yet", 32'(step_err), 0);
    pulse_step();
    chk("R8 step_err pulse", 32'(step_err), 1);
    cyc(1);
    chk("R8 step_err one cycle", 32'(step_err), 0);
    chk("R8 still halted", 32'(running), 0);
    step_done = 1'b1; cyc(2); step_done = 1'b0;
    chk("R8 halted sticky", 32'(running), 0);
    chk("R10 sr halted", 32'(sr_out), 32'h2700);
  endtask

  task automatic t_halt_in_fetch();
    logic [31:0] v;
    do_reset();
    pulse_step();
    rd_ack = 1'b1; rd_data = 16'hAAAA; @(negedge clk);
    rd_ack = 1'b0;
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    chk("R7 fetch abort rd_req", 32'(rd_req), 0);
    chk("R7 fetch abort busy", 32'(busy), 0);
    chk("R7 fetch abort running", 32'(running), 0);
    rd_bank(15, v); chk("R7 ssp not loaded", v, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fetch(16'h0010, 16'h2000, 16'h00FE, 16'h0400, 3);
    t_exec();
    t_halt();
    do_reset();
    t_fetch(16'hDEAD, 16'hBEEF, 16'h1234, 16'h5678, 0);
    t_exec();
    step_done = 1'b1; @(negedge clk); step_done = 1'b0;
    t_halt();
    t_halt_in_fetch();
    do_reset();
    t_fetch(16'hFFFF, 16'h0001, 16'h8000, 16'hFFFE, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule